// File: doc/BRIEF.md
# Block-Transfer Synchronous Serial Port

This block is an 8-bit clocked serial port that moves a whole block of bytes without processor help. Software fills a small local buffer, writes a byte count and sets a start bit. The engine then sends the buffer contents one byte after another. At the same time it writes each byte received from the line back into the buffer slot the sent byte came from. When the count runs out it raises a one-cycle interrupt and sets a done flag.

The serial clock is generated internally (master) or taken from the pin (slave). Bit order is selectable per transfer. An optional active-low chip-select mode gates the transfer and releases the clock and data outputs while the select is high. If the select rises while a byte is half shifted, the transfer is abandoned and an error flag is raised.

The processor side is a plain address/data port. Buffer slots sit at addresses 0 to DEPTH-1. The registers sit above them: the address bit just above the buffer index is set, and the two low address bits pick the register.

Top module: `sio_autoxfer`

## Requirements
- R1: After reset the port is idle. sckOut=1, sckOe=0, sdOe=1, sdOut=1 and irq=0. The control register (select 0) and the status register (select 2) both read 0.
- R2: Each unit is 8 bits. With control bit 2 clear, the most significant bit is sent and received first. With it set, the least significant bit is first.
- R3: The count register (select 1) holds 5 bits. A value of 1 to 31 moves that many bytes, and 0 moves 32. Byte k is sent from buffer slot k, starting at 0. The byte received during that slot replaces slot k.
- R4: With control bit 1 set (master), sckOe=1 and sckOut idles high. During a transfer each low phase lasts 8 system clocks and each clock period lasts 16.
- R5: sdOut changes only when the serial clock falls. sdIn is captured when the serial clock rises.
- R6: With control bit 1 clear (slave), sckOe=0. Each bit is paced by falling and rising edges on sckIn.
- R7: After the last rising edge of the last byte, irq pulses for exactly one cycle. Status then reads busy=0 (bit 0) and done=1 (bit 1), and sckOut is high.
- R8: With control bit 3 set (select mode), sdOe=0 and sckOe=0 while csN is high, and clock edges have no effect. While csN is low the outputs are enabled and bits shift.
- R9: A rise of csN inside a byte in select mode abandons the transfer. Busy clears, error (status bit 2) sets and no irq is raised. The partly shifted byte is not written to the buffer.
- R10: Writing 1 to status bit 1 or bit 2 clears done or error. While busy, writes to the control register, the count register and the buffer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 6 | Buffer slot (bit 5 = 0) or register select (bit 5 = 1, bits 1:0) |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| irq | output | 1 | One-cycle completion pulse |
| sckIn | input | 1 | Serial clock from the pin (slave) |
| sckOut | output | 1 | Generated serial clock, idle high |
| sckOe | output | 1 | Drive enable for sckOut |
| sdIn | input | 1 | Serial data in |
| sdOut | output | 1 | Serial data out |
| sdOe | output | 1 | Drive enable for sdOut |
| csN | input | 1 | Active-low chip select |

## Verification
In master mode, sdOut and sckOut change on the same clock edge, and irq rises on the edge of the eighth rise of the last byte. The bench therefore samples every pin on the falling clock edge, one half cycle after any change. In slave mode and for csN, a pin change reaches the logic after two synchronizer stages, and its effect appears on the third clock edge. The bench holds each slave clock phase for six cycles and reads sdOut just before raising sckIn. It waits four cycles after moving csN before checking the enables. Register and buffer reads are combinational, so the bench reads them one nanosecond after setting the address.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // Register selects inside the register window
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_STAT  = 2'd2;

  // Strobes from the control FSM to the shift/buffer datapath
  typedef struct packed {
    logic restart;  // new transfer: address to 0, preload slot 0
    logic fall;     // serial clock fell: drive next bit
    logic rise;     // serial clock rose: capture sdIn
    logic commit;   // eighth rise: store received byte, advance
  } sioStrobe_t;

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stageQ;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= RESET_VAL;
          else       stageQ[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[g] <= RESET_VAL;
          else       stageQ[g] <= stageQ[g-1];
        end
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int HALF_PERIOD = 8,
  parameter int BITS        = 8,
  parameter int DATA_W      = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWr,
  input  logic [1:0]               regSel,
  input  logic [DATA_W-1:0]        regWrData,
  input  logic                     sckSync,
  input  logic                     csSync,
  output logic [DATA_W-1:0]        ctrlQ,
  output logic [$clog2(DEPTH)-1:0] countQ,
  output logic [DATA_W-1:0]        statusQ,
  output logic                     lsbFirst,
  output logic                     sckOut,
  output logic                     sckOe,
  output logic                     sdOe,
  output logic                     irq,
  output sioStrobe_t               strobe
);

  localparam int CNT_W = $clog2(DEPTH);
  localparam int DIV_W = $clog2(HALF_PERIOD);
  localparam int BIT_W = $clog2(BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_PERIOD - 1);
  localparam logic [DIV_W-1:0] DIV_ONE  = DIV_W'(1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);
  localparam logic [BIT_W-1:0] BIT_ONE  = BIT_W'(1);
  localparam logic [CNT_W:0]   REM_ONE  = (CNT_W+1)'(1);
  localparam logic [CNT_W:0]   REM_FULL = (CNT_W+1)'(DEPTH);

  logic             master, csMode;
  logic             busy, done, error;
  logic [CNT_W:0]   remain;
  logic [BIT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             sckPrev, csLowPrev, midByte;

  logic csLow, gateOpen, csRose, divWrap, masterTick;
  logic slaveFall, slaveRise, fallEv, riseEv, abortEv;
  logic lastBit, lastByte, commitEv, startReq;
  logic unusedWr;

  assign unusedWr   = ^regWrData[DATA_W-1:4];

  assign csLow      = !csSync;
  assign gateOpen   = !csMode || csLow;
  assign csRose     = csLowPrev && !csLow;
  assign divWrap    = (divCnt == DIV_LAST);
  assign masterTick = busy && master && gateOpen && divWrap;
  assign slaveFall  = sckPrev && !sckSync;
  assign slaveRise  = !sckPrev && sckSync;
  assign fallEv     = busy && gateOpen && (master ? (divWrap && sckOut)  : slaveFall);
  assign riseEv     = busy && gateOpen && (master ? (divWrap && !sckOut) : slaveRise);
  assign abortEv    = busy && csMode && csRose && midByte;
  assign lastBit    = (bitCnt == BIT_LAST);
  assign lastByte   = (remain == REM_ONE);
  assign commitEv   = riseEv && lastBit;
  assign startReq   = regWr && (regSel == SEL_CTRL) && regWrData[0] && !busy;

  assign strobe = '{restart: startReq, fall: fallEv, rise: riseEv, commit: commitEv};

  assign ctrlQ   = DATA_W'({csMode, lsbFirst, master, 1'b0});
  assign statusQ = DATA_W'({error, done, busy});
  assign sckOe   = master && gateOpen;
  assign sdOe    = gateOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      master    <= 1'b0;
      lsbFirst  <= 1'b0;
      csMode    <= 1'b0;
      countQ    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      remain    <= '0;
      bitCnt    <= '0;
      divCnt    <= '0;
      sckOut    <= 1'b1;
      sckPrev   <= 1'b1;
      csLowPrev <= 1'b0;
      midByte   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      sckPrev   <= sckSync;
      csLowPrev <= csLow;
      irq       <= 1'b0;

      if (regWr && !busy) begin
        if (regSel == SEL_CTRL)  {csMode, lsbFirst, master} <= regWrData[3:1];
        if (regSel == SEL_COUNT) countQ <= regWrData[CNT_W-1:0];
      end
      if (regWr && (regSel == SEL_STAT)) begin
        if (regWrData[1]) done  <= 1'b0;
        if (regWrData[2]) error <= 1'b0;
      end

      if (startReq) begin
        busy    <= 1'b1;
        done    <= 1'b0;
        error   <= 1'b0;
        remain  <= (countQ == '0) ? REM_FULL : {1'b0, countQ};
        bitCnt  <= '0;
        divCnt  <= '0;
        midByte <= 1'b0;
        sckOut  <= 1'b1;
      end else if (busy) begin
        if (abortEv) begin
          busy    <= 1'b0;
          error   <= 1'b1;
          midByte <= 1'b0;
          sckOut  <= 1'b1;
        end else begin
          if (master && gateOpen) divCnt <= divWrap ? '0 : divCnt + DIV_ONE;
          if (masterTick) sckOut <= !sckOut;
          if (fallEv) midByte <= 1'b1;
          if (riseEv) bitCnt <= lastBit ? '0 : bitCnt + BIT_ONE;
          if (commitEv) begin
            midByte <= 1'b0;
            remain  <= remain - REM_ONE;
            if (lastByte) begin
              busy <= 1'b0;
              done <= 1'b1;
              irq  <= 1'b1;
            end
          end
        end
      end
    end
  end

  // Checker-only phase timer: cycles since sckOut last changed
  logic             chkSckPrev;
  logic [DIV_W:0]   phaseCnt;
  localparam logic [DIV_W:0] PH_MAX  = (DIV_W+1)'(HALF_PERIOD);
  localparam logic [DIV_W:0] PH_NEED = (DIV_W+1)'(HALF_PERIOD - 1);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkSckPrev <= 1'b1;
      phaseCnt   <= PH_MAX;
    end else begin
      chkSckPrev <= sckOut;
      if (sckOut != chkSckPrev) phaseCnt <= '0;
      else if (phaseCnt < PH_MAX) phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // R4: a generated clock phase never ends early
  a_r4_min_phase: assert property (@(posedge clk) disable iff (!rstN)
    (busy && master && (sckOut != chkSckPrev)) |-> (phaseCnt >= PH_NEED));

  // R3: remaining byte count stays within 1..DEPTH while running
  a_r3_remain_range: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ((remain != '0) && (remain <= REM_FULL)));

  // R7: the interrupt pulse goes with done and idle
  a_r7_irq_done: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (done && !busy));

  // R9: an abort leaves error set, idle, and no interrupt
  a_r9_abort_flags: assert property (@(posedge clk) disable iff (!rstN)
    abortEv |=> (error && !busy && !irq));

endmodule

// File: rtl/sio_dp.sv
module sio_dp
  import sio_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int BITS  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sioStrobe_t               strobe,
  input  logic                     lsbFirst,
  input  logic                     sdIn,
  input  logic                     cpuWr,
  input  logic [$clog2(DEPTH)-1:0] cpuAddr,
  input  logic [BITS-1:0]          cpuWrData,
  output logic [BITS-1:0]          cpuRdData,
  output logic                     sdOut
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);

  logic [BITS-1:0] bufMem [DEPTH];
  logic [BITS-1:0] txShift, rxShift, rxNext;
  logic [AW-1:0]   addrQ, addrNext;

  assign addrNext  = addrQ + ADDR_ONE;
  assign cpuRdData = bufMem[cpuAddr];

  always_comb begin
    if (lsbFirst) rxNext = {sdIn, rxShift[BITS-1:1]};
    else          rxNext = {rxShift[BITS-2:0], sdIn};
  end

  always_ff @(posedge clk) begin
    if (strobe.commit)  bufMem[addrQ]   <= rxNext;
    else if (cpuWr)     bufMem[cpuAddr] <= cpuWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      addrQ   <= '0;
      sdOut   <= 1'b1;
    end else begin
      if (strobe.restart) begin
        addrQ   <= '0;
        txShift <= bufMem[0];
        rxShift <= '0;
      end else begin
        if (strobe.fall) begin
          sdOut   <= lsbFirst ? txShift[0] : txShift[BITS-1];
          txShift <= lsbFirst ? (txShift >> 1) : (txShift << 1);
        end
        if (strobe.rise) rxShift <= rxNext;
        if (strobe.commit) begin
          addrQ   <= addrNext;
          txShift <= bufMem[addrNext];
        end
      end
    end
  end

  logic fallSeen;
  assign fallSeen = strobe.fall;

  // R5: the data output moves only on a falling serial clock
  a_r5_out_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdOut) |-> $past(fallSeen));

endmodule

// File: rtl/sio_autoxfer.sv
module sio_autoxfer
  import sio_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int HALF_PERIOD = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [$clog2(DEPTH):0]   busAddr,
  input  logic                     busWrEn,
  input  logic [DATA_W-1:0]        busWrData,
  output logic [DATA_W-1:0]        busRdData,
  output logic                     irq,
  input  logic                     sckIn,
  output logic                     sckOut,
  output logic                     sckOe,
  input  logic                     sdIn,
  output logic                     sdOut,
  output logic                     sdOe,
  input  logic                     csN
);

  localparam int AW = $clog2(DEPTH);

  logic              sckSync, csSync, regWin, regWr, ramWr, lsbFirst;
  logic [DATA_W-1:0] ctrlQ, statusQ, ramRd, regRd;
  logic [AW-1:0]     countQ;
  sioStrobe_t        strobe;

  assign regWin = busAddr[AW];
  assign regWr  = busWrEn && regWin;
  assign ramWr  = busWrEn && !regWin && !statusQ[0];

  sio_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sckSync (
    .clk(clk), .rstN(rstN), .din(sckIn), .dout(sckSync));

  sio_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_csSync (
    .clk(clk), .rstN(rstN), .din(csN), .dout(csSync));

  sio_ctrl #(.DEPTH(DEPTH), .HALF_PERIOD(HALF_PERIOD), .BITS(DATA_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(busAddr[1:0]), .regWrData(busWrData),
    .sckSync(sckSync), .csSync(csSync), .ctrlQ(ctrlQ), .countQ(countQ), .statusQ(statusQ),
    .lsbFirst(lsbFirst), .sckOut(sckOut), .sckOe(sckOe), .sdOe(sdOe), .irq(irq),
    .strobe(strobe));

  sio_dp #(.DEPTH(DEPTH), .BITS(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lsbFirst(lsbFirst), .sdIn(sdIn),
    .cpuWr(ramWr), .cpuAddr(busAddr[AW-1:0]), .cpuWrData(busWrData),
    .cpuRdData(ramRd), .sdOut(sdOut));

  always_comb begin
    case (busAddr[1:0])
      SEL_CTRL:  regRd = ctrlQ;
      SEL_COUNT: regRd = DATA_W'(countQ);
      SEL_STAT:  regRd = statusQ;
      default:   regRd = '0;
    endcase
  end

  assign busRdData = regWin ? regRd : ramRd;

endmodule

// File: tb/sio_autoxfer_bench.sv
module sio_autoxfer_bench;

  localparam int DEPTH = 32;
  localparam logic [5:0] A_CTRL = 6'd32;
  localparam logic [5:0] A_CNT  = 6'd33;
  localparam logic [5:0] A_STAT = 6'd34;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN, busWrEn, irq, sckIn, sckOut, sckOe, sdIn, sdOut, sdOe, csN;
  logic [5:0] busAddr;
  logic [7:0] busWrData, busRdData;
  logic       useModel, modelSd, taskSd;

  assign sdIn = useModel ? modelSd : taskSd;

  sio_autoxfer u_sio_autoxfer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irq(irq), .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .sdIn(sdIn), .sdOut(sdOut), .sdOe(sdOe), .csN(csN));

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] txB [DEPTH];   // bytes loaded into the buffer
  logic [7:0] mTx [DEPTH];   // bytes the far end sends
  logic [7:0] mRx [DEPTH];   // bytes the far end receives
  int  mByte, mBit, lowRun, sinceFall, minLow, maxLow, minPer, maxPer, irqCount;
  bit  mLsb, fallSeen;
  logic prevSck = 1'b1;

  function automatic logic bitOf(input logic [7:0] b, input int i, input bit lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic resetModel();
    mByte = 0; mBit = 0; fallSeen = 0; lowRun = 0; sinceFall = 0;
    minLow = 1000; maxLow = 0; minPer = 1000; maxPer = 0;
  endtask

  // Far-end model for master transfers, plus irq counter
  always @(negedge clk) begin
    if (irq) irqCount++;
    if (prevSck && !sckOut) begin
      if (fallSeen) begin
        if (sinceFall + 1 < minPer) minPer = sinceFall + 1;
        if (sinceFall + 1 > maxPer) maxPer = sinceFall + 1;
      end
      fallSeen = 1; sinceFall = 0;
      if (mByte < DEPTH) modelSd = bitOf(mTx[mByte], mBit, mLsb);
    end else begin
      sinceFall++;
    end
    if (!sckOut) lowRun++;
    if (!prevSck && sckOut) begin
      if (lowRun < minLow) minLow = lowRun;
      if (lowRun > maxLow) maxLow = lowRun;
      lowRun = 0;
      if (mByte < DEPTH) mRx[mByte][mLsb ? mBit : 7 - mBit] = sdOut;
      mBit++;
      if (mBit == 8) begin mBit = 0; mByte++; end
    end
    prevSck = sckOut;
  end

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; #1; d = busRdData;
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    int n = 0;
    do begin busRead(A_STAT, s); n++; end while (s[0] && n < 20000);
    repeat (2) @(negedge clk);
  endtask

  task automatic slaveBits(input logic [7:0] b, input bit lsb, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sckIn = 1'b0; taskSd = bitOf(b, i, lsb);
      repeat (6) @(negedge clk);
      rx[lsb ? i : 7 - i] = sdOut;
      sckIn = 1'b1;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic loadBuf(input int count);
    for (int i = 0; i < count; i++) begin
      txB[i] = 8'($urandom);
      mTx[i] = 8'($urandom);
      busWrite(6'(i), txB[i]);
    end
  endtask

  task automatic runMaster(input int count, input bit lsb);
    logic [7:0] d;
    int irq0;
    loadBuf(count);
    busWrite(A_CNT, 8'(count % 32));
    resetModel(); mLsb = lsb; useModel = 1'b1;
    irq0 = irqCount;
    busWrite(A_CTRL, 8'h03 | (8'(lsb) << 2));
    check(sckOe === 1'b1, "R4 master drives clock", int'(sckOe), 1);
    waitIdle();
    for (int i = 0; i < count; i++) begin
      check(mRx[i] === txB[i], "R2 sent byte order", int'(mRx[i]), int'(txB[i]));
      busRead(6'(i), d);
      check(d === mTx[i], "R3 received byte stored in slot", int'(d), int'(mTx[i]));
    end
    check(mByte == count, "R3 bytes moved for count", mByte, count);
    check(irqCount == irq0 + 1, "R7 one irq pulse", irqCount - irq0, 1);
    busRead(A_STAT, d);
    check(d === 8'h02, "R7 status done", int'(d), 2);
    check(sckOut === 1'b1, "R7 clock idle high", int'(sckOut), 1);
    check(minLow == 8 && maxLow == 8, "R4 low phase 8 clocks", maxLow, 8);
    check(minPer == 16 && maxPer == 16, "R4 period 16 clocks", maxPer, 16);
  endtask

  task automatic runSlave(input int count, input bit lsb);
    logic [7:0] d, rx;
    int irq0;
    loadBuf(count);
    busWrite(A_CNT, 8'(count));
    useModel = 1'b0;
    irq0 = irqCount;
    busWrite(A_CTRL, 8'h01 | (8'(lsb) << 2));
    repeat (2) @(negedge clk);
    check(sckOe === 1'b0, "R6 slave leaves clock undriven", int'(sckOe), 0);
    for (int i = 0; i < count; i++) begin
      slaveBits(mTx[i], lsb, 8, rx);
      check(rx === txB[i], "R6 R2 slave sent byte", int'(rx), int'(txB[i]));
    end
    waitIdle();
    for (int i = 0; i < count; i++) begin
      busRead(6'(i), d);
      check(d === mTx[i], "R5 R3 slave captured byte", int'(d), int'(mTx[i]));
    end
    check(irqCount == irq0 + 1, "R7 slave irq pulse", irqCount - irq0, 1);
  endtask

  initial begin
    logic [7:0] d, rx;
    logic       sdBefore;
    int         irq0, cnt;
    void'($urandom(32'h5eed));
    irqCount = 0;
    rstN = 1'b0; busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    sckIn = 1'b1; csN = 1'b1; taskSd = 1'b0; useModel = 1'b0; modelSd = 1'b0;
    resetModel();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(sckOut === 1'b1, "R1 sckOut", int'(sckOut), 1);
    check(sckOe === 1'b0, "R1 sckOe", int'(sckOe), 0);
    check(sdOe === 1'b1, "R1 sdOe", int'(sdOe), 1);
    check(sdOut === 1'b1, "R1 sdOut", int'(sdOut), 1);
    check(irq === 1'b0, "R1 irq", int'(irq), 0);
    busRead(A_STAT, d); check(d === 8'h00, "R1 status", int'(d), 0);
    busRead(A_CTRL, d); check(d === 8'h00, "R1 control", int'(d), 0);

    // Master, directed then random
    runMaster(3, 1'b0);
    for (int k = 0; k < 3; k++) begin
      cnt = 1 + int'($urandom % 31);
      runMaster(cnt, bit'($urandom % 2));
    end
    runMaster(1, 1'b1);
    runMaster(32, 1'b1);   // R3 count 0 means 32

    // Slave both orders
    runSlave(2, 1'b0);
    runSlave(2, 1'b1);

    // R8 select mode gating
    loadBuf(1);
    busWrite(A_CNT, 8'd1);
    useModel = 1'b0; csN = 1'b1;
    irq0 = irqCount;
    busWrite(A_CTRL, 8'h09);
    repeat (4) @(negedge clk);
    check(sdOe === 1'b0, "R8 data released while deselected", int'(sdOe), 0);
    check(sckOe === 1'b0, "R8 clock released while deselected", int'(sckOe), 0);
    sdBefore = sdOut;
    slaveBits(8'hA5, 1'b0, 8, rx);
    check(sdOut === sdBefore, "R8 sdOut unchanged while deselected", int'(sdOut), int'(sdBefore));
    busRead(A_STAT, d); check(d === 8'h01, "R8 edges ignored while deselected", int'(d), 1);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    check(sdOe === 1'b1, "R8 data driven while selected", int'(sdOe), 1);
    slaveBits(mTx[0], 1'b0, 8, rx);
    check(rx === txB[0], "R8 byte sent while selected", int'(rx), int'(txB[0]));
    waitIdle();
    busRead(A_STAT, d); check(d === 8'h02, "R8 R7 done in select mode", int'(d), 2);
    check(irqCount == irq0 + 1, "R8 irq in select mode", irqCount - irq0, 1);
    csN = 1'b1;
    repeat (4) @(negedge clk);

    // R9 abort inside a byte
    loadBuf(2);
    busWrite(A_CNT, 8'd2);
    irq0 = irqCount;
    busWrite(A_CTRL, 8'h09);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    slaveBits(mTx[0], 1'b0, 8, rx);
    slaveBits(mTx[1], 1'b0, 3, rx);
    csN = 1'b1;
    repeat (8) @(negedge clk);
    busRead(A_STAT, d); check(d === 8'h04, "R9 error set and idle", int'(d), 4);
    check(irqCount == irq0, "R9 no irq on abort", irqCount - irq0, 0);
    busRead(6'd0, d); check(d === mTx[0], "R9 whole byte kept", int'(d), int'(mTx[0]));
    busRead(6'd1, d); check(d === txB[1], "R9 partial byte discarded", int'(d), int'(txB[1]));
    check(sckOe === 1'b0 && sdOe === 1'b0, "R8 outputs floated after rise", int'(sdOe), 0);

    // R10 status clear
    busWrite(A_STAT, 8'h04);
    busRead(A_STAT, d); check(d === 8'h00, "R10 error cleared", int'(d), 0);

    // R10 writes ignored while busy
    busWrite(6'd5, 8'h3C);
    loadBuf(2);
    busWrite(A_CNT, 8'd2);
    resetModel(); mLsb = 1'b0; useModel = 1'b1;
    busWrite(A_CTRL, 8'h03);
    repeat (20) @(negedge clk);
    busWrite(A_CTRL, 8'h01);
    busWrite(A_CNT, 8'd7);
    busWrite(6'd5, 8'hA5);
    check(sckOe === 1'b1, "R10 mode kept while busy", int'(sckOe), 1);
    waitIdle();
    busRead(6'd5, d); check(d === 8'h3C, "R10 buffer write ignored", int'(d), 8'h3C);
    busRead(A_CNT, d); check(d === 8'd2, "R10 count write ignored", int'(d), 2);
    busRead(A_CTRL, d); check(d === 8'h02, "R10 control write ignored", int'(d), 2);
    check(mByte == 2, "R10 transfer unaffected", mByte, 2);
    check(mRx[1] === txB[1], "R10 data unaffected", int'(mRx[1]), int'(txB[1]));
    busWrite(A_STAT, 8'h02);
    busRead(A_STAT, d); check(d === 8'h00, "R10 done cleared", int'(d), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule